// File: doc/BRIEF.md
# Address/Data Write Steering Unit

This block sits beside a microcontroller core that programs registers through a small indirect window. The core holds two address registers, a normal one and a user one, and a single data register. Writing either address register makes it the active pointer. Each later data write is sent to wherever the active pointer refers, and the pointer then advances on its own, so the core can stream a run of values with one address write.

The pointer value picks one of two destinations. A value that fits in the low 16 bits names an offset in the main register file. A value above 0xFFFF selects a pipe register, whose 8-bit index sits in the top byte of the address. In pipe mode the pointer steps by one in the top byte, unless a hold bit is set. Some pipe registers take no data ("void"). An external lookup tells the block which ones are void. When an address write lands on a void pipe register, the block issues a write of zero to it straight away.

All outputs are registered: a write accepted at one rising edge appears on the register-file or pipe port during the following cycle.

Top module: `wsu_top`

## Requirements
- R1: After reset both pointers hold 0, the normal pointer is active, neither write port is asserted and the error flag is 0, so the first data write goes to register-file offset 0.
- R2: Writing an address register (aw_user=0 normal, aw_user=1 user) stores the value and makes that pointer the source for every later data write until the other one is written.
- R3: When the active pointer is at most 0xFFFF, a data write drives rf_we for one cycle in the next cycle, with rf_waddr equal to the pointer's bits 15:0 and rf_wdata equal to the data. The pointer then increases by 1.
- R4: When the active pointer is above 0xFFFF (0x0000FFFF is normal mode and 0x01000000 is pipe mode), a data write drives pipe_we in the next cycle with pipe_widx equal to pointer bits 31:24. rf_we and pipe_we are never both asserted.
- R5: After a pipe-mode data write with bit 18 clear, the pointer increases by 0x01000000. A carry out of bit 31 is dropped, so index 0xFF with all other bits clear wraps to pointer 0, which is normal mode.
- R6: After a pipe-mode data write with pointer bit 18 set, the pointer is left unchanged.
- R7: An address write alone, with a value above 0xFFFF whose bits 31:24 the void lookup (void_idx out, void_hit in) reports as void, drives one pipe write of data 0 to that index in the next cycle. A non-void index produces no write, and an increment that lands on a void index produces no write.
- R8: A pipe-mode data write whose pointer has any bit set outside bits 31:24 and bit 18 (mask 0x00FBFFFF) sets bad_addr_err. The write still proceeds, and the flag stays set until reset.
- R9: When an address write and a data write arrive in the same cycle, the address write is applied first, so the data goes to the new pointer. If that pointer is a void pipe register, only the data write is issued.
- R10: A cycle with neither write enable asserted produces no write on either port in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aw_en | input | 1 | Address register write strobe |
| aw_user | input | 1 | 0 selects the normal pointer, 1 the user pointer |
| aw_value | input | 32 | Address value written |
| dw_en | input | 1 | Data register write strobe |
| dw_value | input | 32 | Data value written |
| void_idx | output | 8 | Pipe index presented to the void lookup (aw_value bits 31:24) |
| void_hit | input | 1 | Lookup answer: void_idx names a void pipe register |
| rf_we | output | 1 | Register-file write strobe |
| rf_waddr | output | 16 | Register-file offset |
| rf_wdata | output | 32 | Register-file write data |
| pipe_we | output | 1 | Pipe-register write strobe |
| pipe_widx | output | 8 | Pipe register index |
| pipe_wdata | output | 32 | Pipe register write data |
| bad_addr_err | output | 1 | Sticky flag for unexpected pipe-address bits |

## Verification
Bursts of data writes are sent from a normal pointer, from a user pointer and from pipe pointers with the hold bit clear and set. These separate the +1 step, the top-byte step and the held pointer. Pointers at 0xFFFF, 0x01000000 and 0xFF000000 mark the mode boundary and the top-byte wrap back into normal mode. Address writes alone, to void and to non-void indices, and increments that walk onto a void index, show that the zero write comes only from an address write. Same-cycle address and data writes, and a pointer that steps from 0xFFFF into a pipe address with stray bits, test the ordering and the sticky error.

// File: rtl/wsu_pkg.sv
package wsu_pkg;
  localparam int NUM_SRC = 2;

  typedef enum logic [0:0] {
    SRC_NORM = 1'b0,
    SRC_USER = 1'b1
  } src_e;
endpackage

// File: rtl/wsu_addr_bank.sv
module wsu_addr_bank
  import wsu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  src_e              ld_sel,
  input  logic [DATA_W-1:0] ld_val,
  input  logic              upd_en,
  input  logic [DATA_W-1:0] upd_val,
  output src_e              eff_sel,
  output logic [DATA_W-1:0] eff_addr
);
  src_e              act_q, act_d;
  logic [DATA_W-1:0] ptr_q [NUM_SRC];
  logic [DATA_W-1:0] ptr_d [NUM_SRC];

  always_comb begin
    act_d    = ld_en ? ld_sel : act_q;
    eff_sel  = act_d;
    eff_addr = ld_en ? ld_val : ptr_q[act_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= SRC_NORM;
    else if (ld_en) act_q <= act_d;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_ptr
    logic ptr_ce;
    always_comb begin
      ptr_d[g] = ptr_q[g];
      if (ld_en && (ld_sel == src_e'(g))) ptr_d[g] = ld_val;
      if (upd_en && (act_d == src_e'(g))) ptr_d[g] = upd_val;
      ptr_ce = (ld_en && (ld_sel == src_e'(g))) || (upd_en && (act_d == src_e'(g)));
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q[g] <= '0;
      else if (ptr_ce) ptr_q[g] <= ptr_d[g];
    end
  end

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !upd_en) |=> ($stable(ptr_q[0]) && $stable(ptr_q[1]) && $stable(act_q)))
    else $error("pointer changed without a write"); // R2
endmodule

// File: rtl/wsu_steer.sv
module wsu_steer #(
  parameter int DATA_W    = 32,
  parameter int RF_AW     = 16,
  parameter int PIPE_IW   = 8,
  parameter int HOLD_BIT  = 18
) (
  input  logic               ld_en,
  input  logic [DATA_W-1:0]  ld_val,
  input  logic               void_hit,
  input  logic               dat_en,
  input  logic [DATA_W-1:0]  dat_val,
  input  logic [DATA_W-1:0]  eff_addr,
  output logic [PIPE_IW-1:0] query_idx,
  output logic               upd_en,
  output logic [DATA_W-1:0]  upd_val,
  output logic               rf_en,
  output logic [RF_AW-1:0]   rf_addr,
  output logic [DATA_W-1:0]  rf_data,
  output logic               pp_en,
  output logic [PIPE_IW-1:0] pp_idx,
  output logic [DATA_W-1:0]  pp_data,
  output logic               err_set
);
  localparam int                PIPE_LSB  = DATA_W - PIPE_IW;
  localparam logic [DATA_W-1:0] ONE       = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] PIPE_STEP = ONE << PIPE_LSB;
  localparam logic [DATA_W-1:0] HOLD_MASK = ONE << HOLD_BIT;
  localparam logic [DATA_W-1:0] TOP_MASK  = {{PIPE_IW{1'b1}}, {PIPE_LSB{1'b0}}};
  localparam logic [DATA_W-1:0] BAD_MASK  = ~(TOP_MASK | HOLD_MASK);

  logic ld_pipe, eff_pipe;

  always_comb begin
    query_idx = ld_val[DATA_W-1 -: PIPE_IW];
    ld_pipe   = |ld_val[DATA_W-1:RF_AW];
    eff_pipe  = |eff_addr[DATA_W-1:RF_AW];
    upd_en    = 1'b0;
    upd_val   = eff_addr;
    rf_en     = 1'b0;
    rf_addr   = eff_addr[RF_AW-1:0];
    rf_data   = dat_val;
    pp_en     = 1'b0;
    pp_idx    = eff_addr[DATA_W-1 -: PIPE_IW];
    pp_data   = dat_val;
    err_set   = 1'b0;
    if (dat_en) begin
      upd_en = 1'b1;
      if (eff_pipe) begin
        pp_en   = 1'b1;
        err_set = |(eff_addr & BAD_MASK);
        upd_val = (|(eff_addr & HOLD_MASK)) ? eff_addr : eff_addr + PIPE_STEP;
      end else begin
        rf_en   = 1'b1;
        upd_val = eff_addr + ONE;
      end
    end else if (ld_en && ld_pipe && void_hit) begin
      pp_en   = 1'b1;
      pp_idx  = query_idx;
      pp_data = '0;
    end
  end

  always_comb begin
    assert (!(rf_en && pp_en)) else $error("both ports chosen"); // R4
  end
endmodule

// File: rtl/wsu_out_stage.sv
module wsu_out_stage #(
  parameter int DATA_W  = 32,
  parameter int RF_AW   = 16,
  parameter int PIPE_IW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rf_en,
  input  logic [RF_AW-1:0]   rf_addr,
  input  logic [DATA_W-1:0]  rf_data,
  input  logic               pp_en,
  input  logic [PIPE_IW-1:0] pp_idx,
  input  logic [DATA_W-1:0]  pp_data,
  input  logic               err_set,
  output logic               rf_we,
  output logic [RF_AW-1:0]   rf_waddr,
  output logic [DATA_W-1:0]  rf_wdata,
  output logic               pipe_we,
  output logic [PIPE_IW-1:0] pipe_widx,
  output logic [DATA_W-1:0]  pipe_wdata,
  output logic               err_q
);
  logic err_d;

  always_comb err_d = err_q | err_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_we   <= 1'b0;
      pipe_we <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      rf_we   <= rf_en;
      pipe_we <= pp_en;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_waddr <= '0;
      rf_wdata <= '0;
    end else if (rf_en) begin
      rf_waddr <= rf_addr;
      rf_wdata <= rf_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_widx  <= '0;
      pipe_wdata <= '0;
    end else if (pp_en) begin
      pipe_widx  <= pp_idx;
      pipe_wdata <= pp_data;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q) else $error("error flag cleared"); // R8
endmodule

// File: rtl/wsu_top.sv
module wsu_top
  import wsu_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int RF_AW    = 16,
  parameter int PIPE_IW  = 8,
  parameter int HOLD_BIT = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               aw_en,
  input  logic               aw_user,
  input  logic [DATA_W-1:0]  aw_value,
  input  logic               dw_en,
  input  logic [DATA_W-1:0]  dw_value,
  output logic [PIPE_IW-1:0] void_idx,
  input  logic               void_hit,
  output logic               rf_we,
  output logic [RF_AW-1:0]   rf_waddr,
  output logic [DATA_W-1:0]  rf_wdata,
  output logic               pipe_we,
  output logic [PIPE_IW-1:0] pipe_widx,
  output logic [DATA_W-1:0]  pipe_wdata,
  output logic               bad_addr_err
);
  logic [1:0]         rst_sync;
  logic               rst_int_n;
  src_e               eff_sel;
  logic [DATA_W-1:0]  eff_addr;
  logic               upd_en;
  logic [DATA_W-1:0]  upd_val;
  logic               rf_en, pp_en, err_set;
  logic [RF_AW-1:0]   rf_addr;
  logic [DATA_W-1:0]  rf_data, pp_data;
  logic [PIPE_IW-1:0] pp_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  wsu_addr_bank #(.DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_int_n),
    .ld_en(aw_en), .ld_sel(src_e'(aw_user)), .ld_val(aw_value),
    .upd_en(upd_en), .upd_val(upd_val),
    .eff_sel(eff_sel), .eff_addr(eff_addr)
  );

  wsu_steer #(.DATA_W(DATA_W), .RF_AW(RF_AW), .PIPE_IW(PIPE_IW), .HOLD_BIT(HOLD_BIT)) u_steer (
    .ld_en(aw_en), .ld_val(aw_value), .void_hit(void_hit),
    .dat_en(dw_en), .dat_val(dw_value), .eff_addr(eff_addr),
    .query_idx(void_idx), .upd_en(upd_en), .upd_val(upd_val),
    .rf_en(rf_en), .rf_addr(rf_addr), .rf_data(rf_data),
    .pp_en(pp_en), .pp_idx(pp_idx), .pp_data(pp_data), .err_set(err_set)
  );

  wsu_out_stage #(.DATA_W(DATA_W), .RF_AW(RF_AW), .PIPE_IW(PIPE_IW)) u_out (
    .clk(clk), .rst_n(rst_int_n),
    .rf_en(rf_en), .rf_addr(rf_addr), .rf_data(rf_data),
    .pp_en(pp_en), .pp_idx(pp_idx), .pp_data(pp_data), .err_set(err_set),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .pipe_we(pipe_we), .pipe_widx(pipe_widx), .pipe_wdata(pipe_wdata),
    .err_q(bad_addr_err)
  );

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(rf_we && pipe_we)) else $error("both write ports active"); // R4
  AST_DATA_EMITS: assert property (@(posedge clk) disable iff (!rst_int_n)
    dw_en |=> (rf_we || pipe_we)) else $error("data write lost"); // R3
  AST_VOID_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (aw_en && !dw_en && (|aw_value[DATA_W-1:RF_AW]) && void_hit) |=>
    (pipe_we && (pipe_wdata == '0) && (pipe_widx == $past(aw_value[DATA_W-1 -: PIPE_IW]))))
    else $error("void zero write missing"); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!aw_en && !dw_en) |=> (!rf_we && !pipe_we)) else $error("write without request"); // R10
endmodule

// File: tb/wsu_top_tb.sv
`timescale 1ns/1ps
module wsu_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        aw_en = 1'b0, aw_user = 1'b0, dw_en = 1'b0;
  logic [31:0] aw_value = '0, dw_value = '0;
  logic [7:0]  void_idx;
  logic        void_hit;
  logic        rf_we, pipe_we, bad_addr_err;
  logic [15:0] rf_waddr;
  logic [31:0] rf_wdata, pipe_wdata;
  logic [7:0]  pipe_widx;

  int tests = 0;
  int fails = 0;
  bit running = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign void_hit = (void_idx == 8'h05) || (void_idx == 8'h07);

  wsu_top u_dut (
    .clk(clk), .rst_n(rst_n), .aw_en(aw_en), .aw_user(aw_user), .aw_value(aw_value),
    .dw_en(dw_en), .dw_value(dw_value), .void_idx(void_idx), .void_hit(void_hit),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .pipe_we(pipe_we), .pipe_widx(pipe_widx), .pipe_wdata(pipe_wdata),
    .bad_addr_err(bad_addr_err)
  );

  typedef struct {
    int          kind;
    logic [31:0] a;
    logic [31:0] d;
    bit          err;
    string       req;
  } exp_t;
  exp_t exq[$];
  exp_t me;

  logic [31:0] m_ptr [2];
  int          m_act;
  bit          m_err;

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit is_void(logic [7:0] i);
    return (i == 8'h05) || (i == 8'h07);
  endfunction

  task automatic op(bit aw, bit au, logic [31:0] av, bit dw, logic [31:0] dv, string req);
    exp_t e;
    logic [31:0] a;
    @(negedge clk);
    aw_en = aw; aw_user = au; aw_value = av; dw_en = dw; dw_value = dv;
    e.kind = 0; e.a = '0; e.d = '0; e.req = req;
    if (aw) begin
      m_ptr[au] = av;
      m_act = au;
      if (!dw && av > 32'hFFFF && is_void(av[31:24])) begin
        e.kind = 2; e.a = {24'h0, av[31:24]}; e.d = '0;
      end
    end
    if (dw) begin
      a = m_ptr[m_act];
      if (a > 32'hFFFF) begin
        e.kind = 2; e.a = {24'h0, a[31:24]}; e.d = dv;
        if ((a & 32'h00FBFFFF) != 0) m_err = 1'b1;
        if (!a[18]) m_ptr[m_act] = a + 32'h01000000;
      end else begin
        e.kind = 1; e.a = {16'h0, a[15:0]}; e.d = dv;
        m_ptr[m_act] = a + 1;
      end
    end
    e.err = m_err;
    exq.push_back(e);
  endtask

  task automatic idle(int n, string req);
    for (int i = 0; i < n; i++) op(1'b0, 1'b0, '0, 1'b0, '0, req);
  endtask

  always @(posedge clk) begin
    #2;
    if (running && exq.size() > 0) begin
      me = exq.pop_front();
      case (me.kind)
        0: check(!rf_we && !pipe_we, me.req, "no write", {30'h0, rf_we, pipe_we}, 32'h0);
        1: begin
          check(rf_we && !pipe_we, me.req, "rf strobe", {30'h0, rf_we, pipe_we}, 32'h2);
          check(rf_waddr == me.a[15:0], me.req, "rf addr", {16'h0, rf_waddr}, me.a);
          check(rf_wdata == me.d, me.req, "rf data", rf_wdata, me.d);
        end
        default: begin
          check(pipe_we && !rf_we, me.req, "pipe strobe", {30'h0, rf_we, pipe_we}, 32'h1);
          check(pipe_widx == me.a[7:0], me.req, "pipe idx", {24'h0, pipe_widx}, me.a);
          check(pipe_wdata == me.d, me.req, "pipe data", pipe_wdata, me.d);
        end
      endcase
      check(bad_addr_err == me.err, me.req, "err flag", {31'h0, bad_addr_err}, {31'h0, me.err});
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    m_ptr[0] = '0; m_ptr[1] = '0; m_act = 0; m_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(!rf_we && !pipe_we && !bad_addr_err, "R1", "reset outputs",
          {29'h0, rf_we, pipe_we, bad_addr_err}, 32'h0);
    running = 1'b1;
    // R1 first write to offset 0, R3 then +1
    op(0, 0, '0, 1, 32'hA000_0001, "R1");
    op(0, 0, '0, 1, 32'hA000_0002, "R3");
    // R2/R3 normal pointer burst
    op(1, 0, 32'h0000_0040, 0, '0, "R10");
    op(0, 0, '0, 1, 32'hB000_0001, "R3");
    op(0, 0, '0, 1, 32'hB000_0002, "R3");
    // R2 user pointer becomes active
    op(1, 1, 32'h0000_0100, 0, '0, "R2");
    op(0, 0, '0, 1, 32'hC000_0001, "R2");
    // R4 boundary values
    op(1, 0, 32'h0000_FFFF, 0, '0, "R4");
    op(0, 0, '0, 1, 32'hD000_0001, "R4");
    op(1, 0, 32'h0100_0000, 0, '0, "R4");
    op(0, 0, '0, 1, 32'hD000_0002, "R4");
    // R5 top byte step
    op(1, 1, 32'h0300_0000, 0, '0, "R2");
    op(0, 0, '0, 1, 32'hE000_0001, "R5");
    op(0, 0, '0, 1, 32'hE000_0002, "R5");
    // R6 hold bit
    op(1, 1, 32'h0A04_0000, 0, '0, "R6");
    op(0, 0, '0, 1, 32'hF000_0001, "R6");
    op(0, 0, '0, 1, 32'hF000_0002, "R6");
    // R5 wrap back to normal offset 0
    op(1, 0, 32'hFF00_0000, 0, '0, "R5");
    op(0, 0, '0, 1, 32'h1111_0001, "R5");
    op(0, 0, '0, 1, 32'h1111_0002, "R5");
    // R7 void zero write, and no zero write on increment into a void index
    op(1, 0, 32'h0500_0000, 0, '0, "R7");
    op(0, 0, '0, 1, 32'h2222_0001, "R7");
    op(0, 0, '0, 1, 32'h2222_0002, "R7");
    idle(2, "R7");
    op(0, 0, '0, 1, 32'h2222_0003, "R7");
    // R7 non-void pipe address gives no write
    op(1, 1, 32'h0900_0000, 0, '0, "R7");
    idle(1, "R10");
    // R9 same-cycle address and data
    op(1, 0, 32'h0704_0000, 1, 32'h3333_0001, "R9");
    op(1, 1, 32'h0000_0200, 1, 32'h3333_0002, "R9");
    op(0, 0, '0, 1, 32'h3333_0003, "R9");
    // R8 stray bits: 0xFFFF steps to 0x10000
    op(1, 0, 32'h0000_FFFF, 0, '0, "R8");
    op(0, 0, '0, 1, 32'h4444_0001, "R8");
    op(0, 0, '0, 1, 32'h4444_0002, "R8");
    op(1, 0, 32'h0000_0020, 1, 32'h4444_0003, "R8");
    idle(3, "R8");
    @(negedge clk);
    aw_en = 1'b0; dw_en = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule